// File: doc/BRIEF.md
# SHA-1 Message Schedule Expander

This block turns one 512-bit message block, held as sixteen 32-bit words, into the eighty schedule words that the SHA-1 compression rounds consume, one word per advance strobe. The first sixteen outputs are the stored words themselves. Every later word is the XOR of four earlier words rotated left by one bit. That word is written back over the oldest stored entry, so the store never holds more than sixteen words.

Software or an upstream padder writes the block one word at a time through the load port. Any load restarts the schedule at step 0. The consumer then pulses the advance input once per round. Each accepted advance returns the next word on a registered output, tagged with its step index. After the eightieth word a done flag is raised, and further advances are ignored until the next load.

Top module: `msx_sched_expander`

## Requirements
- R1: While reset is high and on the cycle after it is released, out_valid, done, out_step and out_word are all zero.
- R2: For an accepted advance at step t in 0..15, the cycle after the strobe shows out_valid=1 and out_word equal to the word last loaded at load_idx=t.
- R3: For an accepted advance at step t in 16..79, out_word is rotl1(W[t-16] ^ W[t-14] ^ W[t-8] ^ W[t-3]), where rotl1 moves bit 31 to bit 0.
- R4: Each word computed at step t of 16..79 replaces stored entry t mod 16. A restart after a partial run therefore returns the computed words at the indices that were overwritten.
- R5: Exactly 80 words come out per block. The advance that returns step 79 also sets done. While done is set, advances produce no out_valid and leave out_word unchanged.
- R6: A load (load=1) writes load_word into entry load_idx, returns the step counter to 0 and clears done. An advance in the same cycle as a load is ignored.
- R7: out_valid is high only in the cycle after an accepted advance, and out_word holds its value in every cycle without out_valid.
- R8: out_step equals the step index t of the word shown on out_word, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write one block word and restart the schedule |
| load_idx | input | 4 | Word index 0..15 for the load |
| load_word | input | 32 | Word data for the load |
| adv | input | 1 | Advance strobe: request the next schedule word |
| out_valid | output | 1 | Pulses high for one cycle with each new word |
| out_step | output | 7 | Step index of out_word |
| out_word | output | 32 | Current schedule word |
| done | output | 1 | All 80 words of the block have been issued |

## Verification
Every schedule word is due exactly one clock after the rising edge that samples its advance strobe. The flags (done set, done cleared by a load, out_valid suppressed) settle at that same edge. The bench drives strobes on falling edges and reads the outputs on the next falling edge, half a cycle after the updating edge, and compares them there with a model of the recurrence built inside the bench. During idle gaps it checks at every falling edge that out_valid stays low and out_word does not move. The write-back is made visible by restarting a block after twenty steps and reading back the overwritten entries.

// File: rtl/msx_pkg.sv
package msx_pkg;
  // Tap offsets of the recurrence, taken modulo the block length:
  // t-14, t-8 and t-3 lie 2, 8 and 13 ahead of the oldest entry (t-16).
  localparam int TAP_NEAR = 2;
  localparam int TAP_MID  = 8;
  localparam int TAP_FAR  = 13;

  // Source of the next output word.
  typedef enum logic [0:0] {
    SRC_STORED = 1'b0,
    SRC_MIXED  = 1'b1
  } word_src_e;
endpackage

// File: rtl/msx_word_store.sv
module msx_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_old,
  input  logic [IDX_W-1:0]  rd_idx_near,
  input  logic [IDX_W-1:0]  rd_idx_mid,
  input  logic [IDX_W-1:0]  rd_idx_far,
  output logic [WORD_W-1:0] rd_old,
  output logic [WORD_W-1:0] rd_near,
  output logic [WORD_W-1:0] rd_mid,
  output logic [WORD_W-1:0] rd_far
);
  // Four read ports: a distributed (LUT) memory, single write port.
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // Reads see the contents before this cycle's write.
  assign rd_old  = mem[rd_idx_old];
  assign rd_near = mem[rd_idx_near];
  assign rd_mid  = mem[rd_idx_mid];
  assign rd_far  = mem[rd_idx_far];
endmodule

// File: rtl/msx_mix.sv
module msx_mix #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] w_old,
  input  logic [WORD_W-1:0] w_near,
  input  logic [WORD_W-1:0] w_mid,
  input  logic [WORD_W-1:0] w_far,
  output logic [WORD_W-1:0] mixed
);
  logic [WORD_W-1:0] folded;

  always_comb begin
    folded = w_old ^ w_near ^ w_mid ^ w_far;
    mixed  = {folded[WORD_W-2:0], folded[WORD_W-1]};
  end
endmodule

// File: rtl/msx_step_ctrl.sv
module msx_step_ctrl #(
  parameter int BLK_WORDS = 16,
  parameter int NUM_STEPS = 80,
  localparam int STEP_W   = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic              fire,
  output logic              expand
);
  logic last;

  assign fire   = adv && !load && !done;
  assign last   = (step == STEP_W'(NUM_STEPS - 1));
  assign expand = (step >= STEP_W'(BLK_WORDS));

  always_ff @(posedge clk) begin
    if (rst || load) begin
      step <= '0;
      done <= 1'b0;
    end else if (fire) begin
      step <= step + STEP_W'(1);
      if (last) done <= 1'b1;
    end
  end
endmodule

// File: rtl/msx_sched_expander.sv
module msx_sched_expander #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int NUM_STEPS = 80,
  localparam int IDX_W    = $clog2(BLK_WORDS),
  localparam int STEP_W   = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [WORD_W-1:0] load_word,
  input  logic              adv,
  output logic              out_valid,
  output logic [STEP_W-1:0] out_step,
  output logic [WORD_W-1:0] out_word,
  output logic              done
);
  import msx_pkg::*;

  logic [STEP_W-1:0] step;
  logic              fire;
  logic              expand;
  word_src_e         src;

  logic [IDX_W-1:0]  idx_old, idx_near, idx_mid, idx_far;
  logic [WORD_W-1:0] w_old, w_near, w_mid, w_far, w_mixed, w_next;
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [WORD_W-1:0] st_wr_data;

  msx_step_ctrl #(
    .BLK_WORDS(BLK_WORDS),
    .NUM_STEPS(NUM_STEPS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .adv    (adv),
    .step   (step),
    .done   (done),
    .fire   (fire),
    .expand (expand)
  );

  // Circular addressing: the oldest word W[t-16] lives at t mod BLK_WORDS.
  assign idx_old  = step[IDX_W-1:0];
  assign idx_near = idx_old + IDX_W'(TAP_NEAR);
  assign idx_mid  = idx_old + IDX_W'(TAP_MID);
  assign idx_far  = idx_old + IDX_W'(TAP_FAR);

  msx_word_store #(
    .WORD_W(WORD_W),
    .DEPTH (BLK_WORDS)
  ) u_store (
    .clk         (clk),
    .wr_en       (st_wr_en),
    .wr_idx      (st_wr_idx),
    .wr_data     (st_wr_data),
    .rd_idx_old  (idx_old),
    .rd_idx_near (idx_near),
    .rd_idx_mid  (idx_mid),
    .rd_idx_far  (idx_far),
    .rd_old      (w_old),
    .rd_near     (w_near),
    .rd_mid      (w_mid),
    .rd_far      (w_far)
  );

  msx_mix #(.WORD_W(WORD_W)) u_mix (
    .w_old  (w_old),
    .w_near (w_near),
    .w_mid  (w_mid),
    .w_far  (w_far),
    .mixed  (w_mixed)
  );

  always_comb begin
    src    = expand ? SRC_MIXED : SRC_STORED;
    w_next = (src == SRC_MIXED) ? w_mixed : w_old;
    // A load owns the write port; otherwise an expansion step writes back.
    st_wr_en   = load || (fire && expand);
    st_wr_idx  = load ? load_idx : idx_old;
    st_wr_data = load ? load_word : w_mixed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_step  <= '0;
      out_word  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_step <= step;
        out_word <= w_next;
      end
    end
  end
endmodule

// File: rtl/msx_checker.sv
module msx_checker #(
  parameter int WORD_W    = 32,
  parameter int NUM_STEPS = 80,
  parameter int STEP_W    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              adv,
  input logic              out_valid,
  input logic [STEP_W-1:0] out_step,
  input logic [WORD_W-1:0] out_word,
  input logic              done
);
  AST_VALID_NEEDS_ADV: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(adv && !load && !done)); // R7

  AST_IDLE_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_word)); // R7

  AST_NO_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !out_valid); // R5

  AST_DONE_ON_LAST_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (out_valid && out_step == STEP_W'(NUM_STEPS - 1))); // R5

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!done && !out_valid)); // R6

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_step < STEP_W'(NUM_STEPS))); // R8
endmodule

bind msx_sched_expander msx_checker #(
  .WORD_W   (WORD_W),
  .NUM_STEPS(NUM_STEPS),
  .STEP_W   (STEP_W)
) u_msx_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .adv       (adv),
  .out_valid (out_valid),
  .out_step  (out_step),
  .out_word  (out_word),
  .done      (done)
);

// File: tb/tb_msx_sched_expander.sv
`timescale 1ns/1ps
module tb_msx_sched_expander;
  localparam int WW = 32;
  localparam int NB = 16;
  localparam int NS = 80;
  localparam int NV = 4;
  // Vector fields: {seed[31:0], stride[31:0], idle gap cycles[7:0]}
  localparam logic [71:0] VEC [NV] = '{
    {32'h0123_4567, 32'h1111_1111, 8'd0},
    {32'hFFFF_FFFF, 32'h8000_0001, 8'd2},
    {32'h0000_0000, 32'h0000_0000, 8'd1},
    {32'hA5A5_5A5A, 32'h3C3C_C3C3, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [3:0]    load_idx = '0;
  logic [WW-1:0] load_word = '0;
  logic          adv = 1'b0;
  logic          out_valid;
  logic [6:0]    out_step;
  logic [WW-1:0] out_word;
  logic          done;

  always #2.5 clk = ~clk;

  msx_sched_expander dut (
    .clk(clk), .rst(rst), .load(load), .load_idx(load_idx),
    .load_word(load_word), .adv(adv), .out_valid(out_valid),
    .out_step(out_step), .out_word(out_word), .done(done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [WW-1:0] blk   [NB];
  logic [WW-1:0] ref_w [NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic build_ref();
    for (int t = 0; t < NS; t++) begin
      if (t < NB) ref_w[t] = blk[t];
      else begin
        logic [WW-1:0] x;
        x = ref_w[t-16] ^ ref_w[t-14] ^ ref_w[t-8] ^ ref_w[t-3];
        ref_w[t] = {x[WW-2:0], x[WW-1]};
      end
    end
  endtask

  task automatic load_one(input int idx, input logic [WW-1:0] data);
    @(negedge clk);
    load = 1'b1; load_idx = 4'(idx); load_word = data;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic load_block();
    for (int i = 0; i < NB; i++) load_one(i, blk[i]);
  endtask

  task automatic step_once(output logic [WW-1:0] w, output logic v,
                           output logic [6:0] s);
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
    w = out_word; v = out_valid; s = out_step;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [WW-1:0] w, held;
    logic v;
    logic [6:0] s;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", WW'(out_valid), '0);
    chk(done == 1'b0, "R1", "done in reset", WW'(done), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_word == '0, "R1", "out_word after reset", out_word, '0);
    chk(out_step == '0, "R1", "out_step after reset", WW'(out_step), '0);
    chk(done == 1'b0 && out_valid == 1'b0, "R1", "flags after reset",
        WW'({done, out_valid}), '0);

    // Table walk: full 80-word schedules, optional idle gaps
    for (int vi = 0; vi < NV; vi++) begin
      logic [WW-1:0] seed, stride;
      int gap;
      seed = VEC[vi][71:40]; stride = VEC[vi][39:8]; gap = int'(VEC[vi][7:0]);
      for (int i = 0; i < NB; i++) blk[i] = seed + stride * WW'(i);
      build_ref();
      load_block();
      chk(done == 1'b0, "R6", "done after load", WW'(done), '0);
      for (int t = 0; t < NS; t++) begin
        step_once(w, v, s);
        chk(v == 1'b1, "R2", "valid after advance", WW'(v), 32'd1);
        chk(w == ref_w[t], (t < 16) ? "R2" : ((t < 32) ? "R3" : "R4"),
            $sformatf("word %0d", t), w, ref_w[t]);
        chk(s == 7'(t), "R8", "step index", WW'(s), WW'(t));
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(out_valid == 1'b0 && out_word == ref_w[t], "R7",
              "idle hold", out_word, ref_w[t]);
        end
        if (t == NS - 2)
          chk(done == 1'b0, "R5", "done before last word", WW'(done), '0);
      end
      chk(done == 1'b1, "R5", "done after 80 words", WW'(done), 32'd1);
    end

    // R5: advances after done are ignored
    held = out_word;
    step_once(w, v, s);
    chk(v == 1'b0, "R5", "no valid after done", WW'(v), '0);
    chk(w == held, "R5", "word unchanged after done", w, held);
    chk(done == 1'b1, "R5", "done stays", WW'(done), 32'd1);

    // R6: load and advance in the same cycle, load wins
    @(negedge clk);
    load = 1'b1; adv = 1'b1; load_idx = 4'd0; load_word = 32'h1357_9BDF;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
    chk(out_valid == 1'b0, "R6", "advance ignored with load", WW'(out_valid), '0);
    chk(done == 1'b0, "R6", "load clears done", WW'(done), '0);
    step_once(w, v, s);
    chk(v && w == 32'h1357_9BDF && s == 7'd0, "R6", "restart at step 0",
        w, 32'h1357_9BDF);

    // R3 known answer: one-block padded "abc"
    for (int i = 0; i < NB; i++) blk[i] = '0;
    blk[0] = 32'h6162_6380; blk[15] = 32'h0000_0018;
    build_ref();
    load_block();
    for (int t = 0; t < 17; t++) step_once(w, v, s);
    chk(w == 32'hC2C4_C700, "R3", "abc word 16", w, 32'hC2C4_C700);

    // R4: after 20 steps reload one entry; entries 0..3 now hold W16..W19
    for (int t = 17; t < 20; t++) step_once(w, v, s);
    load_one(5, 32'hDEAD_BEEF);
    for (int i = 0; i < NB; i++) begin
      logic [WW-1:0] e;
      e = (i < 4) ? ref_w[16+i] : ((i == 5) ? 32'hDEAD_BEEF : ref_w[i]);
      step_once(w, v, s);
      chk(v && w == e, "R4", $sformatf("write-back entry %0d", i), w, e);
    end

    finish_run();
  end
endmodule